// File: doc/BRIEF.md
# External Interrupt Line Controller

This block collects eight external interrupt pins and turns them into one prioritized request toward a CPU. Each line is first passed through a clock-domain synchronizer. It is then watched by a detector that is set per line to low level, any change, falling edge or rising edge. Edge events latch into a flag bit that software reads and clears by writing a one. The same flag also clears itself when the CPU acknowledges that line's request. A line in level mode keeps no flag; its request follows the pin directly for as long as the pin is low.

A pending line is forwarded only when its mask bit and the global enable input are both one. Among the forwarded lines, the lowest-numbered line wins. The winning index is held on the request port until the CPU pulses acknowledge, or until that line stops pending.

The block does not look at pin direction, so a pin the chip drives itself still raises requests. Driving such a pin is therefore a way to raise an interrupt from software.

A sleep input models the input buffers of the four lowest lines being switched off. While sleep is high, any of lines 3..0 whose mask bit is zero reads as logic 0. The transition this causes can set that line's flag.

Top module: `exti_ctrl`

## Requirements
- R1: After reset all four registers read 0x00 and `irq_req_o` is 0.
- R2: The register map is: address 0 holds the sense fields of lines 3..0, address 1 holds those of lines 7..4 (line n uses bits [2k+1:2k] with k = n mod 4), address 2 holds the mask and address 3 holds the flags (bit n = line n). The sense codes are 00 = low level, 01 = any change, 10 = falling edge and 11 = rising edge.
- R3: A qualifying pin transition becomes visible in the flag register after exactly three rising clock edges. The flag still reads 0 after two edges.
- R4: Writing to the flag address clears each flag whose data bit is one. Flags whose data bit is zero keep their value.
- R5: A line in level mode never reads a set flag. It requests while its pin is low and stops requesting once the pin is high again.
- R6: A request appears on `irq_req_o` only while the line's mask bit is one and `gie_i` is one.
- R7: The lowest-numbered pending line wins. Once `irq_idx_o` is presented it does not change while `irq_req_o` stays high, even if a lower line becomes pending.
- R8: An acknowledge pulse while `irq_req_o` is high clears the flag of the presented line and drops `irq_req_o` on the next cycle. The next winner is presented one cycle after that.
- R9: If a flag's set event and its clear (by write-one or by acknowledge) fall on the same clock edge, the flag is left set.
- R10: While `sleep_i` is high, each of lines 3..0 with a mask bit of zero sees its pin as 0. Lines 7..4, and low lines whose mask bit is one, are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_i | input | 8 | Asynchronous external interrupt pins |
| sleep_i | input | 1 | Sleep state; disables unmasked-off low-line input buffers |
| gie_i | input | 1 | Global interrupt enable from the CPU |
| bus_addr_i | input | 2 | Register address |
| bus_wr_i | input | 1 | Register write strobe |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data (combinational on address) |
| irq_req_o | output | 1 | Interrupt request to the CPU |
| irq_idx_o | output | 3 | Index of the requesting line |
| irq_ack_i | input | 1 | CPU acknowledge (vector entry) pulse |

## Verification
The bench builds the block with its default parameters: eight lines, a two-stage synchronizer and four sleep-gated lines. With eight lines, every line can be taken through every sense code with both starting pin levels, and the flag is checked on the edge before and the edge of its expected arrival. Every one of the 255 non-empty pending patterns is driven into the arbiter and drained acknowledge by acknowledge. The bench's own lowest-bit computation gives the expected order, and the flag register is checked after each acknowledge.

// File: rtl/exti_pkg.sv
package exti_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam logic [1:0] ADR_SENSE_LO = 2'd0;
  localparam logic [1:0] ADR_SENSE_HI = 2'd1;
  localparam logic [1:0] ADR_MASK     = 2'd2;
  localparam logic [1:0] ADR_FLAG     = 2'd3;

  // Edge qualification between the previous and the current synchronized level.
  function automatic logic edge_hit(input logic [1:0] mode, input logic prev, input logic cur);
    case (mode)
      SENSE_ANY:  return prev ^ cur;
      SENSE_FALL: return prev & ~cur;
      SENSE_RISE: return ~prev & cur;
      default:    return 1'b0;
    endcase
  endfunction

  // Level request: active while the synchronized pin is low in level mode.
  function automatic logic level_hit(input logic [1:0] mode, input logic cur);
    return (mode == SENSE_LOW) && !cur;
  endfunction

endpackage

// File: rtl/exti_sync.sv
module exti_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/exti_line_detect.sv
module exti_line_detect
  import exti_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sense_i,
  input  logic       sync_i,
  input  logic       clr_i,
  output logic       flag_o,
  output logic       level_req_o,
  output logic       set_evt_o
);

  logic prev_q;
  logic flag_q;
  logic is_level;

  assign is_level    = (sense_i == SENSE_LOW);
  assign set_evt_o   = edge_hit(sense_i, prev_q, sync_i);
  assign level_req_o = level_hit(sense_i, sync_i);
  assign flag_o      = flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= sync_i;
      if (is_level)       flag_q <= 1'b0;
      else if (set_evt_o) flag_q <= 1'b1;
      else if (clr_i)     flag_q <= 1'b0;
    end
  end

  // R9: a set event wins over any concurrent clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt_o |=> flag_o);

  // R5: level mode leaves no flag behind
  p_level_no_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    level_req_o |=> !flag_o);

endmodule

// File: rtl/exti_prio.sv
module exti_prio #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end

  // R7: the chosen index is itself pending
  p_win_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> req_i[idx_o]);

  // R7: no lower-numbered line is pending
  p_no_lower_r7: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> ((req_i & ((N'(1) << idx_o) - N'(1))) == '0));

endmodule

// File: rtl/exti_ctrl.sv
module exti_ctrl
  import exti_pkg::*;
#(
  parameter int NUM_LINES   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SLEEP_LINES = 4,
  parameter int DATA_W      = 8,
  localparam int IDX_W      = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_LINES-1:0] pins_i,
  input  logic              sleep_i,
  input  logic              gie_i,
  input  logic [1:0]        bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_req_o,
  output logic [IDX_W-1:0]  irq_idx_o,
  input  logic              irq_ack_i
);

  localparam int SENSE_W = 2 * NUM_LINES;

  logic [SENSE_W-1:0]   sense_q;
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] pin_eff;
  logic [NUM_LINES-1:0] pin_sync;
  logic [NUM_LINES-1:0] flag_vec;
  logic [NUM_LINES-1:0] level_vec;
  logic [NUM_LINES-1:0] set_evt_vec;
  logic [NUM_LINES-1:0] clr_vec;
  logic [NUM_LINES-1:0] pend_vec;
  logic                 pend_any;
  logic [IDX_W-1:0]     win_idx;
  logic                 req_valid_q;
  logic [IDX_W-1:0]     req_idx_q;
  logic                 ack_hit;
  logic                 wr_flag;

  // Register writes
  assign wr_flag = bus_wr_i && (bus_addr_i == ADR_FLAG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sense_q <= '0;
      mask_q  <= '0;
    end else if (bus_wr_i) begin
      case (bus_addr_i)
        ADR_SENSE_LO: sense_q[DATA_W-1:0]           <= bus_wdata_i;
        ADR_SENSE_HI: sense_q[SENSE_W-1 -: DATA_W]   <= bus_wdata_i;
        ADR_MASK:     mask_q                        <= bus_wdata_i[NUM_LINES-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr_i)
      ADR_SENSE_LO: bus_rdata_o = sense_q[DATA_W-1:0];
      ADR_SENSE_HI: bus_rdata_o = sense_q[SENSE_W-1 -: DATA_W];
      ADR_MASK:     bus_rdata_o = DATA_W'(mask_q);
      default:      bus_rdata_o = DATA_W'(flag_vec);
    endcase
  end

  // Sleep gating of the low-line input buffers
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_gate
    if (g < SLEEP_LINES) begin : g_low
      assign pin_eff[g] = pins_i[g] & ~(sleep_i & ~mask_q[g]);
    end else begin : g_high
      assign pin_eff[g] = pins_i[g];
    end
  end

  exti_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_eff),
    .q_o   (pin_sync)
  );

  // Clears: write-one from software, or acknowledge of the presented line
  assign ack_hit = irq_ack_i && req_valid_q;
  assign clr_vec = (wr_flag ? bus_wdata_i[NUM_LINES-1:0] : '0)
                 | (ack_hit ? (NUM_LINES'(1) << req_idx_q) : '0);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    exti_line_detect u_det (
      .clk         (clk),
      .rst_n       (rst_n),
      .sense_i     (sense_q[2*g +: 2]),
      .sync_i      (pin_sync[g]),
      .clr_i       (clr_vec[g]),
      .flag_o      (flag_vec[g]),
      .level_req_o (level_vec[g]),
      .set_evt_o   (set_evt_vec[g])
    );
    assign pend_vec[g] = (level_vec[g] | flag_vec[g]) & mask_q[g] & gie_i;
  end

  exti_prio #(.N(NUM_LINES)) u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (pend_vec),
    .any_o (pend_any),
    .idx_o (win_idx)
  );

  // Request hold: index frozen until acknowledge or withdrawal
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid_q <= 1'b0;
      req_idx_q   <= '0;
    end else if (req_valid_q) begin
      if (ack_hit || !pend_vec[req_idx_q]) req_valid_q <= 1'b0;
    end else if (pend_any) begin
      req_valid_q <= 1'b1;
      req_idx_q   <= win_idx;
    end
  end

  assign irq_req_o = req_valid_q;
  assign irq_idx_o = req_idx_q;

  // R6: a fresh request needs the global enable in the cycle before
  p_req_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req_o) |-> $past(gie_i));

  // R7: presented index holds while the request stays up
  p_idx_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_o && !irq_ack_i) |=> (!irq_req_o || $stable(irq_idx_o)));

  // R8: acknowledge drops the request on the next cycle
  p_ack_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_o && irq_ack_i) |=> !irq_req_o);

  // R8: acknowledge clears the flag unless a new event lands at once
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !set_evt_vec[req_idx_q]) |=> !flag_vec[$past(req_idx_q)]);

endmodule

// File: tb/tb_exti_ctrl.sv
module tb_exti_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = 8'h00;
  logic       sleep = 1'b0;
  logic       gie = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq_req;
  logic [2:0] irq_idx;
  logic       ack = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  exti_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .sleep_i(sleep), .gie_i(gie),
    .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_req_o(irq_req), .irq_idx_o(irq_idx), .irq_ack_i(ack)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    step(1);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    step(1);
    ack = 1'b0;
  endtask

  function automatic int lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] rem;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1: reset values
    for (int a = 0; a < 4; a++) begin
      bus_read(2'(a), rd);
      chk("R1 reg", rd, 0);
    end
    chk("R1 irq_req", irq_req, 0);

    // R2/R3/R5: every line x sense code x starting level
    for (int line = 0; line < 8; line++) begin
      for (int m = 0; m < 4; m++) begin
        for (int old = 0; old < 2; old++) begin
          int exp;
          logic [7:0] sfield;
          sfield = {4{2'(m)}};
          pins = old ? 8'hFF : 8'h00;
          step(3);
          bus_write(2'd0, sfield);
          bus_write(2'd1, sfield);
          step(2);
          bus_write(2'd3, 8'hFF);
          pins[line] = ~pins[line];
          step(2);
          bus_read(2'd3, rd);
          chk("R3 early", rd, 0);
          step(1);
          exp = ((m == 1) || (m == 2 && old == 1) || (m == 3 && old == 0)) ? (1 << line) : 0;
          bus_read(2'd3, rd);
          if (m == 0) chk("R5 level flag", rd, 0);
          else        chk("R2 sense", rd, exp);
        end
      end
    end
    bus_read(2'd1, rd);
    chk("R2 readback", rd, 8'hFF);

    // R6: mask and global enable gating
    bus_write(2'd0, 8'hFF); bus_write(2'd1, 8'hFF);
    pins = 8'h00; step(3);
    bus_write(2'd3, 8'hFF);
    pins = 8'h08; step(4);
    chk("R6 masked", irq_req, 0);
    bus_read(2'd3, rd); chk("R6 flag", rd, 8'h08);
    bus_write(2'd2, 8'h08); step(2);
    chk("R6 gie off", irq_req, 0);
    gie = 1'b1; step(1);
    chk("R6 req", irq_req, 1);
    chk("R6 idx", irq_idx, 3);
    gie = 1'b0; step(1);
    chk("R6 withdraw", irq_req, 0);
    bus_write(2'd3, 8'hFF);

    // R7/R8: index held, then acknowledged in order
    bus_write(2'd2, 8'hFF); gie = 1'b1;
    pins = 8'h00; step(3); bus_write(2'd3, 8'hFF);
    pins = 8'h10; step(4);
    chk("R7 first idx", irq_idx, 4);
    pins = 8'h12; step(4);
    chk("R7 held req", irq_req, 1);
    chk("R7 held idx", irq_idx, 4);
    pulse_ack();
    chk("R8 drop", irq_req, 0);
    bus_read(2'd3, rd); chk("R8 flag clr", rd, 8'h02);
    step(1);
    chk("R8 next idx", irq_idx, 1);
    pulse_ack(); step(1);
    chk("R8 empty", irq_req, 0);

    // R5: level mode on line 5
    bus_write(2'd1, 8'hF3);
    pins = 8'h20; step(4);
    chk("R5 high idle", irq_req, 0);
    pins = 8'h00; step(3);
    chk("R5 level req", irq_req, 1);
    chk("R5 level idx", irq_idx, 5);
    bus_read(2'd3, rd); chk("R5 no flag", rd, 0);
    pins = 8'h20; step(3);
    chk("R5 released", irq_req, 0);

    // R9 and R4: set vs clear collision, then write-one-to-clear
    gie = 1'b0; bus_write(2'd2, 8'h00);
    bus_write(2'd0, 8'hFF); bus_write(2'd1, 8'hFF);
    pins = 8'h00; step(3); bus_write(2'd3, 8'hFF);
    pins = 8'h40; step(2);
    bus_write(2'd3, 8'h40);
    bus_read(2'd3, rd); chk("R9 set wins", rd, 8'h40);
    bus_write(2'd3, 8'h40);
    bus_read(2'd3, rd); chk("R4 cleared", rd, 0);
    pins = 8'h00; step(3);
    pins = 8'h0F; step(3);
    bus_write(2'd3, 8'h05);
    bus_read(2'd3, rd); chk("R4 partial", rd, 8'h0A);
    bus_write(2'd3, 8'h00);
    bus_read(2'd3, rd); chk("R4 zero write", rd, 8'h0A);

    // R10: sleep gating on low lines
    bus_write(2'd0, 8'hAA); bus_write(2'd1, 8'hAA);
    bus_write(2'd2, 8'h02);
    pins = 8'hFF; step(3); bus_write(2'd3, 8'hFF);
    sleep = 1'b1; step(3);
    bus_read(2'd3, rd); chk("R10 gated", rd, 8'h0D);
    sleep = 1'b0; step(3);
    bus_read(2'd3, rd); chk("R10 wake", rd, 8'h0D);
    bus_write(2'd3, 8'hFF);

    // R7/R8: full priority sweep
    bus_write(2'd0, 8'hFF); bus_write(2'd1, 8'hFF);
    bus_write(2'd2, 8'hFF); gie = 1'b1;
    for (int p = 1; p < 256; p++) begin
      pins = 8'h00; step(3);
      bus_write(2'd3, 8'hFF);
      pins = 8'(p); step(4);
      rem = 8'(p);
      while (rem != 8'h00) begin
        int e;
        e = lowest(rem);
        chk("R7 req", irq_req, 1);
        chk("R7 prio", irq_idx, e);
        pulse_ack();
        rem[e] = 1'b0;
        chk("R8 ack drop", irq_req, 0);
        bus_read(2'd3, rd); chk("R8 ack flag", rd, rem);
        step(1);
      end
      chk("R8 drained", irq_req, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule